// File: doc/BRIEF.md
# Wake-on-Address Two-Wire Bus Front End

This block watches a two-wire serial bus while the rest of the system sleeps and wakes the system only when a bus master addresses it. While asleep the local slave clock is stopped. The block therefore captures a START condition asynchronously and raises a clock request at once. It also holds SCL low, so the master waits until the clock controller reports that the slave clock runs. The length of that wait depends on how deep the system sleeps. The block then releases SCL and receives the first byte with only itself clocked.

If the first byte carries the high-speed master-code prefix, the block enters high-speed mode, sends no acknowledge, and waits for a repeated START followed by the address byte. If the address byte matches the configured address, the block acknowledges it and raises a wake request for the whole system. If it does not match, the block drops its clock request on its own and the system falls back into sleep. High-speed mode lasts until a STOP is seen on the bus. The wake request is held until the transaction ends with a STOP.

Top module: `wake_addr_frontend`

## Requirements
- R1: On a START (SDA falling while SCL is high) seen in the asleep state, `clk_req_o` and `scl_oe_o` rise with no clock edge needed, and `scl_oe_o` stays high for as long as `clk_rdy_i` stays low, however long that is.
- R2: Once `clk_rdy_i` is high at a clock edge during the stretch, `scl_oe_o` is low no later than the second rising clock edge after `clk_rdy_i` rises.
- R3: A first byte whose upper five bits are 00001 sets `hs_mode_o` and gets no acknowledge (SDA stays high in the ninth clock). The address is taken from the byte that follows the next repeated START.
- R4: An address byte whose bits 7..1 (sent first) equal the `OWN_ADDR` parameter raises `wake_o` by the fourth clock edge after the eighth SCL rising edge, whatever the value of bit 0 (read/write). `clk_req_o` stays high while `wake_o` is high.
- R5: After a matching address, `sda_oe_o` pulls SDA low from the SCL falling edge that ends bit eight to the SCL falling edge that ends the ninth clock. It is never driven at any other time.
- R6: After a non-matching address byte, `clk_req_o` is low by the fourth clock edge after the eighth SCL rising edge. `wake_o` stays low and no acknowledge is given.
- R7: `hs_mode_o` stays high after it is set, also across a return to sleep after a non-matching address. It is cleared only when a STOP (SDA rising while SCL is high) is detected.
- R8: A STOP after a wake clears `wake_o` and `clk_req_o` within five clock cycles.
- R9: After reset, `scl_oe_o`, `sda_oe_o`, `clk_req_o`, `wake_o` and `hs_mode_o` are all low.
- R10: SCL pulses with SDA changing only while SCL is low (no START) leave `clk_req_o` and `scl_oe_o` low while asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slave clock, gated by the system while asleep |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_oe_o | output | 1 | Open-drain pull-down of SCL (1 = hold low) |
| sda_oe_o | output | 1 | Open-drain pull-down of SDA (1 = drive low, acknowledge) |
| clk_req_o | output | 1 | Request to start and keep the slave clock |
| clk_rdy_i | input | 1 | Slave clock is running, synchronous to clk_i |
| wake_o | output | 1 | Wake request for the whole system |
| hs_mode_o | output | 1 | High-speed mode active |

## Verification
The START response is combinational. The bench checks `clk_req_o` and `scl_oe_o` one nanosecond after SDA falls, then again after a long ready delay. The SCL release is due on the second edge after `clk_rdy_i` is raised between edges. Every bus-side decision passes through a two-stage synchronizer and the state register, so it lands on the third clock edge after the SCL change. The bench therefore samples wake and clock-request results just after the fourth edge following the eighth SCL rise. It samples acknowledge and high-speed state in the middle of SCL phases, at least ten cycles after the causing edge.

// File: rtl/wake_addr_pkg.sv
package wake_addr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_STRETCH = 3'd1,
        ST_RX_HEAD = 3'd2,
        ST_WAIT_RS = 3'd3,
        ST_RX_ADDR = 3'd4,
        ST_ACK     = 3'd5,
        ST_AWAKE   = 3'd6
    } wk_state_e;

    typedef struct packed {
        wk_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-2:0]  shreg;
        logic               req;
        logic               wake;
        logic               hs;
        logic               ack_on;
        logic               scl_prev;
        logic               start_seen;
        logic               stop_seen;
    } wk_core_t;

endpackage

// File: rtl/bus_cond_toggle.sv
module bus_cond_toggle (
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_tgl_o,
    output logic stop_tgl_o
);

    logic start_tgl_q;
    logic stop_tgl_q;

    // START: data falls while clock high; needs no slave clock
    always_ff @(negedge sda_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_tgl_q <= 1'b0;
        end else if (scl_i) begin
            start_tgl_q <= ~start_tgl_q;
        end
    end

    // STOP: data rises while clock high
    always_ff @(posedge sda_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stop_tgl_q <= 1'b0;
        end else if (scl_i) begin
            stop_tgl_q <= ~stop_tgl_q;
        end
    end

    assign start_tgl_o = start_tgl_q;
    assign stop_tgl_o  = stop_tgl_q;

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '0;
                else         stg_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '0;
                else         stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/wake_addr_frontend.sv
module wake_addr_frontend
    import wake_addr_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter logic [4:0] MC_PREFIX   = 5'b00001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic clk_req_o,
    input  logic clk_rdy_i,
    output logic wake_o,
    output logic hs_mode_o
);

    localparam int          SYNC_W   = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              start_tgl;
    logic              stop_tgl;
    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic              scl_s;
    logic              sda_s;
    logic              start_s;
    logic              stop_s;

    wk_core_t q, d;

    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              start_pend;
    logic [BYTE_W-1:0] byte_nx;

    bus_cond_toggle u_cond (
        .rst_ni      (rst_ni),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .start_tgl_o (start_tgl),
        .stop_tgl_o  (stop_tgl)
    );

    assign sync_in = {stop_tgl, start_tgl, sda_i, scl_i};

    bit_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sync_in),
        .q_o    (sync_out)
    );

    assign scl_s   = sync_out[0];
    assign sda_s   = sync_out[1];
    assign start_s = sync_out[2];
    assign stop_s  = sync_out[3];

    // START captured but not yet seen by the clocked logic
    assign start_pend = start_tgl ^ q.start_seen;

    always_comb begin
        d = q;

        scl_rise  = scl_s & ~q.scl_prev;
        scl_fall  = ~scl_s & q.scl_prev;
        start_evt = start_s ^ q.start_seen;
        stop_evt  = stop_s ^ q.stop_seen;
        byte_nx   = {q.shreg, sda_s};

        d.scl_prev   = scl_s;
        d.start_seen = start_s;
        d.stop_seen  = stop_s;

        if (stop_evt) begin
            d.hs = 1'b0;
        end

        if (stop_evt && (q.st != ST_SLEEP)) begin
            d.st     = ST_SLEEP;
            d.req    = 1'b0;
            d.wake   = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            unique case (q.st)
                ST_SLEEP: begin
                    d.req = 1'b0;
                    if (start_evt) begin
                        d.st  = ST_STRETCH;
                        d.req = 1'b1;
                    end
                end

                ST_STRETCH: begin
                    if (clk_rdy_i) begin
                        d.st  = ST_RX_HEAD;
                        d.cnt = '0;
                    end
                end

                ST_RX_HEAD, ST_RX_ADDR: begin
                    if (start_evt) begin
                        d.cnt = '0;
                    end else if (scl_rise) begin
                        d.shreg = byte_nx[BYTE_W-2:0];
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            if ((q.st == ST_RX_HEAD) && (byte_nx[7:3] == MC_PREFIX)) begin
                                d.hs = 1'b1;
                                d.st = ST_WAIT_RS;
                            end else if (byte_nx[7:1] == OWN_ADDR) begin
                                d.st     = ST_ACK;
                                d.wake   = 1'b1;
                                d.ack_on = 1'b0;
                            end else begin
                                d.st  = ST_SLEEP;
                                d.req = 1'b0;
                            end
                        end
                    end
                end

                ST_WAIT_RS: begin
                    if (start_evt) begin
                        d.st  = ST_RX_ADDR;
                        d.cnt = '0;
                    end
                end

                ST_ACK: begin
                    if (scl_fall) begin
                        if (!q.ack_on) begin
                            d.ack_on = 1'b1;
                        end else begin
                            d.ack_on = 1'b0;
                            d.st     = ST_AWAKE;
                        end
                    end
                end

                ST_AWAKE: begin
                    d.wake = 1'b1;
                end

                default: begin
                    d.st  = ST_SLEEP;
                    d.req = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_SLEEP, cnt: '0, shreg: '0, req: 1'b0, wake: 1'b0,
                   hs: 1'b0, ack_on: 1'b0, scl_prev: 1'b0,
                   start_seen: 1'b0, stop_seen: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe_o  = (q.st == ST_STRETCH) | ((q.st == ST_SLEEP) & start_pend);
    assign clk_req_o = q.req | ((q.st == ST_SLEEP) & start_pend);
    assign sda_oe_o  = (q.st == ST_ACK) & q.ack_on;
    assign wake_o    = q.wake;
    assign hs_mode_o = q.hs;

endmodule

// File: rtl/wake_addr_frontend_chk.sv
module wake_addr_frontend_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic clk_req_o,
    input logic clk_rdy_i,
    input logic wake_o,
    input logic hs_mode_o
);

    AST_STRETCH_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_oe_o && !clk_rdy_i) |=> scl_oe_o); // R1

    AST_STRETCH_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_oe_o |-> clk_req_o); // R1

    AST_NO_STRETCH_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> !scl_oe_o); // R2

    AST_WAKE_KEEPS_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> clk_req_o); // R4

    AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_oe_o |-> wake_o); // R5

    AST_HS_RISE_CLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_mode_o) |-> (clk_req_o && !wake_o)); // R3

endmodule

bind wake_addr_frontend wake_addr_frontend_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .clk_req_o (clk_req_o),
    .clk_rdy_i (clk_rdy_i),
    .wake_o    (wake_o),
    .hs_mode_o (hs_mode_o)
);

// File: tb/sim_wake_addr_frontend.sv
module sim_wake_addr_frontend;

    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic clk_rdy = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe, clk_req, wake, hs;
    int   n_chk = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    wake_addr_frontend #(.OWN_ADDR(OWN)) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe),
        .clk_req_o (clk_req),
        .clk_rdy_i (clk_rdy),
        .wake_o    (wake),
        .hs_mode_o (hs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // START from sleep with a clock controller that needs dly cycles
    task automatic m_wake_start(input int dly);
        sda_m = 1'b0;
        #1;
        chk("R1 clk_req at START", 32'(clk_req), 1);
        chk("R1 scl hold at START", 32'(scl_oe), 1);
        #99 scl_m = 1'b0;
        repeat (dly) @(posedge clk);
        #1;
        chk("R1 scl still held", 32'(scl_oe), 1);
        #4 clk_rdy = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R2 scl released", 32'(scl_oe), 0);
    endtask

    task automatic m_bit(input logic b);
        sda_m = b;
        #200 scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        #400 scl_m = 1'b0;
        #200;
    endtask

    // sends 8 bits, returns four edges after the 8th SCL rise with SCL high
    task automatic m_byte_open(input logic [7:0] b);
        for (int i = 7; i > 0; i--) m_bit(b[i]);
        sda_m = b[0];
        #200 scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic m_byte_close();
        #300 scl_m = 1'b0;
        #200;
    endtask

    task automatic m_ack9(output logic acked);
        sda_m = 1'b1;
        #200 scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        #200 acked = ~sda_bus;
        #200 scl_m = 1'b0;
        #200;
    endtask

    task automatic m_rstart();
        sda_m = 1'b1;
        #200 scl_m = 1'b1;
        #200 sda_m = 1'b0;
        #100 scl_m = 1'b0;
        #200;
    endtask

    task automatic m_stop();
        sda_m = 1'b0;
        #200 scl_m = 1'b1;
        #200 sda_m = 1'b1;
        #200;
        repeat (5) @(posedge clk);
        #1;
        if (!clk_req) clk_rdy = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 scl_oe", 32'(scl_oe), 0);
        chk("R9 sda_oe", 32'(sda_oe), 0);
        chk("R9 clk_req", 32'(clk_req), 0);
        chk("R9 wake", 32'(wake), 0);
        chk("R9 hs", 32'(hs), 0);
    endtask

    task automatic t_noise();
        for (int i = 0; i < 6; i++) begin
            scl_m = 1'b0;
            #100 sda_m = i[0];
            #100 scl_m = 1'b1;
            #200;
        end
        sda_m = 1'b1;
        #200;
        chk("R10 no clk_req on noise", 32'(clk_req), 0);
        chk("R10 no stretch on noise", 32'(scl_oe), 0);
    endtask

    task automatic t_match(input logic rw, input int dly);
        logic a;
        m_wake_start(dly);
        m_byte_open({OWN, rw});
        chk("R4 wake on match", 32'(wake), 1);
        chk("R4 clk_req held", 32'(clk_req), 1);
        chk("R5 no ack during bit 8", 32'(sda_oe), 0);
        m_byte_close();
        chk("R5 ack driven after bit 8", 32'(sda_oe), 1);
        m_ack9(a);
        chk("R5 ack seen in 9th clock", 32'(a), 1);
        chk("R5 ack released", 32'(sda_oe), 0);
        chk("R4 wake kept", 32'(wake), 1);
        m_stop();
        chk("R8 wake cleared by STOP", 32'(wake), 0);
        chk("R8 clk_req cleared by STOP", 32'(clk_req), 0);
    endtask

    task automatic t_nomatch();
        logic a;
        m_wake_start(5);
        m_byte_open({OWN + 7'd1, 1'b0});
        chk("R6 clk_req dropped", 32'(clk_req), 0);
        chk("R6 no wake", 32'(wake), 0);
        clk_rdy = 1'b0;
        m_byte_close();
        m_ack9(a);
        chk("R6 no ack", 32'(a), 0);
        m_stop();
        chk("R6 still asleep", 32'(clk_req), 0);
    endtask

    task automatic t_hs_match();
        logic a;
        m_wake_start(8);
        m_byte_open(8'h0A);
        m_byte_close();
        chk("R3 hs set by master code", 32'(hs), 1);
        chk("R3 no wake on master code", 32'(wake), 0);
        m_ack9(a);
        chk("R3 master code not acked", 32'(a), 0);
        m_rstart();
        m_byte_open({OWN, 1'b0});
        chk("R4 wake after master code", 32'(wake), 1);
        m_byte_close();
        m_ack9(a);
        chk("R5 ack in HS", 32'(a), 1);
        chk("R7 hs held while awake", 32'(hs), 1);
        m_stop();
        chk("R7 hs cleared by STOP", 32'(hs), 0);
        chk("R8 wake cleared", 32'(wake), 0);
    endtask

    task automatic t_hs_nomatch();
        logic a;
        m_wake_start(3);
        m_byte_open(8'h0D);
        m_byte_close();
        m_ack9(a);
        chk("R3 hs set", 32'(hs), 1);
        m_rstart();
        m_byte_open({OWN ^ 7'h10, 1'b1});
        chk("R6 clk_req dropped in HS", 32'(clk_req), 0);
        clk_rdy = 1'b0;
        m_byte_close();
        m_ack9(a);
        chk("R6 no ack in HS", 32'(a), 0);
        chk("R7 hs kept asleep", 32'(hs), 1);
        m_stop();
        chk("R7 hs cleared asleep", 32'(hs), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #5;
        t_reset();
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_noise();
        t_match(1'b0, 40);
        t_nomatch();
        t_match(1'b1, 12);
        t_hs_match();
        t_hs_nomatch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule